// File: doc/BRIEF.md
# Eight-Channel Pulse-Width Modulator

This block produces eight pulse-width modulated outputs from one system clock. Each channel has an 8-bit counter, a period and a duty value, an enable bit, a polarity bit and an alignment bit. The alignment bit chooses between an edge-aligned ramp and a symmetric up/down ramp. The counter advances on ticks from one of four prescaled sources: two power-of-two dividers (A, B) and a further even-ratio divider behind each of them (SA, SB). Software writes period and duty into holding registers. A running channel moves them into its working copy only when its counter returns to zero, so a waveform never sees a half-applied update.

Two neighbouring channels can be joined into one 16-bit channel, which is then governed by the higher channel's enable, clock source, alignment and polarity. An emergency-stop input, when armed, latches a flag and forces every enabled output to a programmed level. That level holds until the input has dropped and software clears the flag. A read port returns any channel's live counter without touching it.

Top module: `pwm8_top`

## Requirements
- R1: After reset all pins are low, the stop flag is 0 and every counter reads 0 (enable, polarity, alignment, join and clock-select fields all reset to 0).
- R2: While a channel's enable bit (address 0x00, bit = channel) is 0 its counter reads 0 and its pin sits at the inactive level. Once the bit is set, the counter reads 1 two clocks after the write edge when the channel ticks every clock.
- R3: With alignment bit 0 (address 0x02) the counter runs 0..P-1 and wraps, so the period is P ticks and the output is active for D ticks (period at 0x10+ch, duty at 0x18+ch).
- R4: A period or duty write to a running channel first lets the current period finish with the old values, and the new values apply from the next counter zero. Writes to a disabled channel are taken up at once.
- R5: With alignment bit 1 the counter runs 0..P..1 and repeats (2P ticks). It peaks at P and the output is active for 2D-1 ticks when 0<D<P.
- R6: Duty 0 gives a permanently inactive output, and duty greater than or equal to the period gives a permanently active output.
- R7: Polarity bit 0 (address 0x01) makes the active level high, and bit 1 makes it low. The change shows on the pin without waiting for a counter zero.
- R8: A channel's 2-bit clock select (address 0x04 for channels 0-3, 0x05 for 4-7, two bits per channel from bit 0) picks 0=A, 1=SA, 2=B, 3=SB. A and B divide the clock by 2^a and 2^b (a at 0x06, b at 0x07). SA and SB divide A and B by 2N and 2M (N at 0x08, M at 0x09, code 0 meaning 256).
- R9: Join bit k (address 0x03) makes channels 2k and 2k+1 one 16-bit channel, with period and duty taken as {high channel, low channel}. Its waveform appears on pin 2k+1 and is gated by enable bit 2k+1 only. Pin 2k stays inactive. Counter reads return the low byte for channel 2k and the high byte for 2k+1.
- R10: The counter read port returns the selected channel's counter, consecutive reads show it advancing, and reading leaves the waveform unchanged.
- R11: With the stop control (address 0x0A) bit 0 set, a high stop input forces every enabled pin to the bit 1 level at the next clock edge and sets the flag. The pins stay forced until the input is low and a write with bit 7 set clears the flag. A clear write while the input is still high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_sel | input | 3 | Channel whose counter is returned |
| rd_data | output | 8 | Counter of the selected channel |
| shut_in | input | 1 | Emergency-stop request |
| pwm_out | output | 8 | Registered PWM pins |
| shut_flag | output | 1 | Latched emergency-stop flag |

## Verification
A wrong working period or a mis-timed shadow load shows at the read port within one counter cycle, as a counter that wraps at the wrong value. It also shows on the pin as a high-cycle count that departs from D/P over a window of whole periods. A divider fault stretches or shrinks the period by the divider ratio, so a window sized for the expected rate gives a different count after a few periods. Shutdown faults show one clock after the stop input rises, or in the cycles after a clear that should not have taken effect.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;
   typedef enum logic [1:0] {SRC_A = 2'd0, SRC_SA = 2'd1, SRC_B = 2'd2, SRC_SB = 2'd3} clk_src_e;
   localparam logic [4:0] A_ENABLE  = 5'h00;
   localparam logic [4:0] A_POLAR   = 5'h01;
   localparam logic [4:0] A_ALIGN   = 5'h02;
   localparam logic [4:0] A_JOIN    = 5'h03;
   localparam logic [4:0] A_CSEL    = 5'h04;
   localparam logic [4:0] A_DIVA    = 5'h06;
   localparam logic [4:0] A_DIVB    = 5'h07;
   localparam logic [4:0] A_SCLA    = 5'h08;
   localparam logic [4:0] A_SCLB    = 5'h09;
   localparam logic [4:0] A_STOP    = 5'h0A;
   localparam logic [4:0] A_PERIOD  = 5'h10;
   localparam logic [4:0] A_DUTY    = 5'h18;
endpackage

// File: rtl/pwm8_clkgen.sv
module pwm8_clkgen #(
   parameter int PRE_W = 3,
   parameter int SCL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PRE_W-1:0] div_a,
   input  logic [PRE_W-1:0] div_b,
   input  logic [SCL_W-1:0] scl_a,
   input  logic [SCL_W-1:0] scl_b,
   output logic [3:0]       ticks
);
   localparam int FW = (1 << PRE_W) - 1;
   localparam int SW = SCL_W + 1;

   logic [FW-1:0] free_q;
   logic [FW-1:0] mask_a, mask_b;
   logic          tick_a, tick_b;
   logic [SW-1:0] sa_q, sb_q;
   logic [SW:0]   full_a, full_b, lim_a, lim_b;

   assign mask_a = ~({FW{1'b1}} << div_a);
   assign mask_b = ~({FW{1'b1}} << div_b);
   assign tick_a = (free_q & mask_a) == mask_a;
   assign tick_b = (free_q & mask_b) == mask_b;

   assign full_a = (scl_a == '0) ? (SW+1)'(1 << SCL_W) : (SW+1)'(scl_a);
   assign full_b = (scl_b == '0) ? (SW+1)'(1 << SCL_W) : (SW+1)'(scl_b);
   assign lim_a  = (full_a << 1) - 1'b1;
   assign lim_b  = (full_b << 1) - 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         free_q <= '0;
         sa_q   <= '0;
         sb_q   <= '0;
      end else begin
         free_q <= free_q + 1'b1;
         if (tick_a) sa_q <= ({1'b0, sa_q} >= lim_a) ? '0 : sa_q + 1'b1;
         if (tick_b) sb_q <= ({1'b0, sb_q} >= lim_b) ? '0 : sb_q + 1'b1;
      end
   end

   assign ticks[0] = tick_a;
   assign ticks[1] = tick_a && ({1'b0, sa_q} >= lim_a);
   assign ticks[2] = tick_b;
   assign ticks[3] = tick_b && ({1'b0, sb_q} >= lim_b);
endmodule

// File: rtl/pwm8_lane.sv
module pwm8_lane #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         tick,
   input  logic         center_h,
   input  logic [W-1:0] per_h,
   input  logic [W-1:0] duty_h,
   output logic [W-1:0] cnt_o,
   output logic         act_o
);
   logic [W-1:0] cnt, nxt, per_a, duty_a;
   logic         down, nxt_dn, ctr_a;

   always_comb begin
      nxt    = cnt + 1'b1;
      nxt_dn = 1'b0;
      if (!ctr_a) begin
         if (per_a == '0 || cnt >= per_a - 1'b1) nxt = '0;
      end else if (!down) begin
         if (cnt >= per_a) begin
            if (cnt <= W'(1)) nxt = '0;
            else begin
               nxt    = cnt - 1'b1;
               nxt_dn = 1'b1;
            end
         end
      end else begin
         nxt    = cnt - 1'b1;
         nxt_dn = cnt > W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         down   <= 1'b0;
         per_a  <= '0;
         duty_a <= '0;
         ctr_a  <= 1'b0;
      end else if (!en) begin
         cnt    <= '0;
         down   <= 1'b0;
         per_a  <= per_h;
         duty_a <= duty_h;
         ctr_a  <= center_h;
      end else if (tick) begin
         cnt  <= nxt;
         down <= nxt_dn;
         if (nxt == '0) begin
            per_a  <= per_h;
            duty_a <= duty_h;
            ctr_a  <= center_h;
         end
      end
   end

   assign cnt_o = cnt;
   assign act_o = en && ((cnt < duty_a) || (duty_a != '0 && duty_a >= per_a));

   // R3
   left_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !ctr_a && per_a != '0) |-> (cnt < per_a));
   // R5
   center_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && ctr_a) |-> (cnt <= per_a));
   // R4
   shadow_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en) && (per_a != $past(per_a) || duty_a != $past(duty_a))) |-> (cnt == '0));
endmodule

// File: rtl/pwm8_pair.sv
module pwm8_pair #(
   parameter int W      = 8,
   parameter bit CAT_EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [1:0]   en,
   input  logic [1:0]   tick,
   input  logic [1:0]   center,
   input  logic         join_q,
   input  logic [W-1:0] per_lo,
   input  logic [W-1:0] per_hi,
   input  logic [W-1:0] duty_lo,
   input  logic [W-1:0] duty_hi,
   output logic [1:0]   act_o,
   output logic [W-1:0] cnt_lo_o,
   output logic [W-1:0] cnt_hi_o
);
   logic         cat;
   logic         act_lo, act_hi, act_w;
   logic [W-1:0] cnt_lo, cnt_hi;
   logic [2*W-1:0] cnt_w;

   pwm8_lane #(.W(W)) u_lo (.clk(clk), .rst_n(rst_n), .en(en[0] && !cat), .tick(tick[0]),
      .center_h(center[0]), .per_h(per_lo), .duty_h(duty_lo), .cnt_o(cnt_lo), .act_o(act_lo));
   pwm8_lane #(.W(W)) u_hi (.clk(clk), .rst_n(rst_n), .en(en[1] && !cat), .tick(tick[1]),
      .center_h(center[1]), .per_h(per_hi), .duty_h(duty_hi), .cnt_o(cnt_hi), .act_o(act_hi));

   generate
      if (CAT_EN) begin : g_wide
         assign cat = join_q;
         pwm8_lane #(.W(2*W)) u_wide (.clk(clk), .rst_n(rst_n), .en(en[1] && cat), .tick(tick[1]),
            .center_h(center[1]), .per_h({per_hi, per_lo}), .duty_h({duty_hi, duty_lo}),
            .cnt_o(cnt_w), .act_o(act_w));
      end else begin : g_narrow
         logic unused_join;
         assign unused_join = join_q;
         assign cat   = 1'b0;
         assign cnt_w = '0;
         assign act_w = 1'b0;
      end
   endgenerate

   assign act_o[0] = cat ? 1'b0  : act_lo;
   assign act_o[1] = cat ? act_w : act_hi;
   assign cnt_lo_o = cat ? cnt_w[W-1:0]   : cnt_lo;
   assign cnt_hi_o = cat ? cnt_w[2*W-1:W] : cnt_hi;
endmodule

// File: rtl/pwm8_top.sv
module pwm8_top
   import pwm8_pkg::*;
#(
   parameter int NCH    = 8,
   parameter int CW     = 8,
   parameter int PRE_W  = 3,
   parameter int SCL_W  = 8,
   parameter bit CAT_EN = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [4:0]             wr_addr,
   input  logic [7:0]             wr_data,
   input  logic [$clog2(NCH)-1:0] rd_sel,
   output logic [CW-1:0]          rd_data,
   input  logic                   shut_in,
   output logic [NCH-1:0]         pwm_out,
   output logic                   shut_flag
);
   localparam int NP = NCH / 2;

   generate
      if (NCH % 2 != 0 || NCH < 2 || NCH > 8) begin : g_bad_nch
         $error("pwm8_top: NCH must be even and between 2 and 8");
      end
      if (CW < 2 || PRE_W < 1 || PRE_W > 4 || SCL_W < 1 || SCL_W > 8) begin : g_bad_w
         $error("pwm8_top: width parameter out of range");
      end
   endgenerate

   logic [NCH-1:0]   en_q, pol_q, ctr_q, act, en_eff, tick_ch, pin_q;
   logic [NP-1:0]    join_q;
   clk_src_e         csel_q [NCH];
   logic [PRE_W-1:0] div_a_q, div_b_q;
   logic [SCL_W-1:0] scl_a_q, scl_b_q;
   logic [CW-1:0]    per_q [NCH];
   logic [CW-1:0]    duty_q [NCH];
   logic [CW-1:0]    cnt_rd [NCH];
   logic [3:0]       ticks;
   logic             sd_en_q, sd_lvl_q, flag_q, sd_trip, sd_force;

   assign sd_trip  = sd_en_q && shut_in;
   assign sd_force = flag_q || sd_trip;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= '0; pol_q <= '0; ctr_q <= '0; join_q <= '0;
         div_a_q <= '0; div_b_q <= '0; scl_a_q <= '0; scl_b_q <= '0;
         sd_en_q <= 1'b0; sd_lvl_q <= 1'b0; flag_q <= 1'b0;
         for (int i = 0; i < NCH; i++) begin
            csel_q[i] <= SRC_A;
            per_q[i]  <= '0;
            duty_q[i] <= '0;
         end
      end else begin
         if (sd_trip) flag_q <= 1'b1;
         else if (wr_en && wr_addr == A_STOP && wr_data[7]) flag_q <= 1'b0;
         if (wr_en) begin
            case (wr_addr)
               A_ENABLE: en_q    <= wr_data[NCH-1:0];
               A_POLAR:  pol_q   <= wr_data[NCH-1:0];
               A_ALIGN:  ctr_q   <= wr_data[NCH-1:0];
               A_JOIN:   join_q  <= wr_data[NP-1:0];
               A_DIVA:   div_a_q <= wr_data[PRE_W-1:0];
               A_DIVB:   div_b_q <= wr_data[PRE_W-1:0];
               A_SCLA:   scl_a_q <= wr_data[SCL_W-1:0];
               A_SCLB:   scl_b_q <= wr_data[SCL_W-1:0];
               A_STOP: begin
                  sd_en_q  <= wr_data[0];
                  sd_lvl_q <= wr_data[1];
               end
               default: ;
            endcase
            for (int i = 0; i < NCH; i++) begin
               if (wr_addr == A_CSEL + 5'(i / 4)) csel_q[i] <= clk_src_e'(wr_data[2*(i%4) +: 2]);
               if (wr_addr == A_PERIOD + 5'(i))   per_q[i]  <= wr_data[CW-1:0];
               if (wr_addr == A_DUTY + 5'(i))     duty_q[i] <= wr_data[CW-1:0];
            end
         end
      end
   end

   pwm8_clkgen #(.PRE_W(PRE_W), .SCL_W(SCL_W)) u_clk (.clk(clk), .rst_n(rst_n),
      .div_a(div_a_q), .div_b(div_b_q), .scl_a(scl_a_q), .scl_b(scl_b_q), .ticks(ticks));

   always_comb begin
      for (int i = 0; i < NCH; i++) tick_ch[i] = ticks[csel_q[i]];
   end

   genvar k;
   generate
      for (k = 0; k < NP; k++) begin : g_pair
         pwm8_pair #(.W(CW), .CAT_EN(CAT_EN)) u_pair (.clk(clk), .rst_n(rst_n),
            .en(en_q[2*k +: 2]), .tick(tick_ch[2*k +: 2]), .center(ctr_q[2*k +: 2]),
            .join_q(join_q[k]), .per_lo(per_q[2*k]), .per_hi(per_q[2*k+1]),
            .duty_lo(duty_q[2*k]), .duty_hi(duty_q[2*k+1]), .act_o(act[2*k +: 2]),
            .cnt_lo_o(cnt_rd[2*k]), .cnt_hi_o(cnt_rd[2*k+1]));
         assign en_eff[2*k]   = en_q[2*k] && !(CAT_EN && join_q[k]);
         assign en_eff[2*k+1] = en_q[2*k+1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_q <= '0;
      else begin
         for (int i = 0; i < NCH; i++)
            pin_q[i] <= (sd_force && en_eff[i]) ? sd_lvl_q : (act[i] ^ pol_q[i]);
      end
   end

   assign pwm_out   = pin_q;
   assign shut_flag = flag_q;
   assign rd_data   = cnt_rd[rd_sel];

   // R11
   shut_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sd_en_q && shut_in) |=> shut_flag);

   generate
      for (k = 0; k < NCH; k++) begin : g_force_chk
         // R11
         shut_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(sd_force && en_eff[k]) |-> (pwm_out[k] == $past(sd_lvl_q)));
      end
   endgenerate
endmodule

// File: tb/pwm8_top_bench.sv
module pwm8_top_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [4:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [2:0] rd_sel = '0;
   logic [7:0] rd_data;
   logic       shut_in = 1'b0;
   logic [7:0] pwm_out;
   logic       shut_flag;

   int n_chk = 0;
   int n_fail = 0;
   logic [7:0] en_s = '0, pol_s = '0, ctr_s = '0;

   always #10 clk = ~clk;

   pwm8_top u_pwm8_top (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .shut_in(shut_in),
      .pwm_out(pwm_out), .shut_flag(shut_flag));

   task automatic chk(input int act, input int exp, input string tag);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic highs(input int ch, input int len, output int cnt);
      cnt = 0;
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         if (pwm_out[ch]) cnt++;
      end
   endtask

   task automatic enable(input int ch);
      en_s[ch] = 1'b1;
      wr(5'h00, en_s);
   endtask

   task automatic t_reset;
      int h;
      chk(pwm_out, 0, "R1 pins after reset");
      chk(shut_flag, 0, "R1 flag after reset");
      rd_sel = 3'd5; @(negedge clk);
      chk(rd_data, 0, "R1 counter after reset");
      highs(2, 20, h);
      chk(h, 0, "R1 pin idle");
   endtask

   task automatic t_left;
      int h;
      wr(5'h10, 8'd10); wr(5'h18, 8'd3);
      rd_sel = 3'd0;
      enable(0);
      @(negedge clk);
      chk(rd_data, 1, "R2 counter starts after enable");
      idle(20);
      highs(0, 100, h);
      chk(h, 30, "R3 left P=10 D=3");
      highs(1, 50, h);
      chk(h, 0, "R2 disabled pin inactive");
      rd_sel = 3'd1; @(negedge clk);
      chk(rd_data, 0, "R2 disabled counter");
   endtask

   task automatic t_counter;
      int c1, c2, h;
      rd_sel = 3'd0;
      @(negedge clk); c1 = rd_data;
      @(negedge clk); c2 = rd_data;
      chk(c2, (c1 + 1) % 10, "R10 counter advances");
      for (int i = 0; i < 25; i++) begin
         @(negedge clk);
         rd_sel = 3'(i % 8);
      end
      rd_sel = 3'd0;
      highs(0, 100, h);
      chk(h, 30, "R10 waveform unchanged by reads");
   endtask

   task automatic t_buffer;
      int prev, cur, seen, h;
      rd_sel = 3'd0;
      wr(5'h10, 8'd20);
      seen = -1;
      @(negedge clk); prev = rd_data;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk); cur = rd_data;
         if (cur == 0 && prev != 0 && seen < 0) seen = prev;
         prev = cur;
      end
      chk(seen, 9, "R4 old period finishes");
      wr(5'h18, 8'd5);
      idle(45);
      highs(0, 200, h);
      chk(h, 50, "R4 new P=20 D=5");
      wr(5'h12, 8'd8); wr(5'h1A, 8'd2);
      enable(2);
      idle(16);
      highs(2, 80, h);
      chk(h, 20, "R4 disabled channel takes values at once");
   endtask

   task automatic t_center;
      int h, mx;
      ctr_s[3] = 1'b1; wr(5'h02, ctr_s);
      wr(5'h13, 8'd6); wr(5'h1B, 8'd2);
      enable(3);
      idle(24);
      highs(3, 120, h);
      chk(h, 30, "R5 center P=6 D=2");
      rd_sel = 3'd3; mx = 0;
      for (int i = 0; i < 24; i++) begin
         @(negedge clk);
         if (rd_data > mx) mx = rd_data;
      end
      chk(mx, 6, "R5 center peak");
   endtask

   task automatic t_extremes;
      int h;
      wr(5'h14, 8'd5); wr(5'h1C, 8'd0);
      enable(4);
      idle(10);
      highs(4, 50, h);
      chk(h, 0, "R6 duty 0");
      wr(5'h1C, 8'd9); idle(12);
      highs(4, 50, h);
      chk(h, 50, "R6 duty above period");
      wr(5'h1C, 8'd5); idle(12);
      highs(4, 50, h);
      chk(h, 50, "R6 duty equal period");
   endtask

   task automatic t_polarity;
      int h;
      wr(5'h1C, 8'd0); idle(12);
      pol_s[4] = 1'b1; wr(5'h01, pol_s);
      @(negedge clk);
      chk(pwm_out[4], 1, "R7 polarity immediate");
      highs(4, 50, h);
      chk(h, 50, "R7 inverted duty 0");
      wr(5'h1C, 8'd2); idle(12);
      highs(4, 50, h);
      chk(h, 30, "R7 inverted P=5 D=2");
   endtask

   task automatic t_clocks;
      int h;
      wr(5'h15, 8'd4); wr(5'h1D, 8'd2);
      enable(5);
      wr(5'h06, 8'd2); idle(40);
      highs(5, 160, h);
      chk(h, 80, "R8 source A div4");
      wr(5'h06, 8'd0); wr(5'h08, 8'd3); wr(5'h05, 8'h04); idle(60);
      highs(5, 240, h);
      chk(h, 120, "R8 source SA N=3");
      wr(5'h07, 8'd1); wr(5'h05, 8'h08); idle(20);
      highs(5, 80, h);
      chk(h, 40, "R8 source B div2");
      wr(5'h09, 8'd2); wr(5'h05, 8'h0C); idle(70);
      highs(5, 320, h);
      chk(h, 160, "R8 source SB M=2");
      wr(5'h15, 8'd2); wr(5'h1D, 8'd1);
      wr(5'h08, 8'd0); wr(5'h05, 8'h04); idle(2100);
      highs(5, 2048, h);
      chk(h, 1024, "R8 SA code 0 means 256");
   endtask

   task automatic t_concat;
      int h, mx;
      wr(5'h16, 8'h2C); wr(5'h17, 8'h01);
      wr(5'h1E, 8'd100); wr(5'h1F, 8'd0);
      wr(5'h03, 8'h08);
      en_s[6] = 1'b1; wr(5'h00, en_s);
      idle(20);
      highs(7, 100, h);
      chk(h, 0, "R9 low enable alone does nothing");
      enable(7);
      idle(20);
      highs(7, 600, h);
      chk(h, 200, "R9 joined P=300 D=100");
      highs(6, 100, h);
      chk(h, 0, "R9 low pin inactive");
      rd_sel = 3'd7; mx = 0;
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         if (rd_data > mx) mx = rd_data;
      end
      chk(mx, 1, "R9 high byte of counter");
   endtask

   task automatic t_shutdown;
      int h;
      wr(5'h0A, 8'h03);
      @(negedge clk);
      shut_in = 1'b1;
      @(negedge clk);
      chk(pwm_out[0], 1, "R11 forced next edge");
      chk(pwm_out[1], 0, "R11 disabled pin untouched");
      chk(shut_flag, 1, "R11 flag latched");
      wr(5'h0A, 8'h83);
      @(negedge clk);
      chk(shut_flag, 1, "R11 clear ignored while stop high");
      shut_in = 1'b0;
      highs(0, 20, h);
      chk(h, 20, "R11 held after release");
      wr(5'h0A, 8'h83);
      @(negedge clk);
      chk(shut_flag, 0, "R11 flag cleared");
      idle(40);
      highs(0, 100, h);
      chk(h, 25, "R11 waveform resumes");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      t_reset();
      t_left();
      t_counter();
      t_buffer();
      t_center();
      t_extremes();
      t_polarity();
      t_clocks();
      t_concat();
      t_shutdown();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule